// File: doc/BRIEF.md
# Gated Timer Channel

This block is one channel of a timer. It has a count register, a compare register and a mode register. A read of the mode address returns status instead of the stored mode. The counter advances on a tick. The tick is either every system clock or an external strobe such as a pixel or line pulse, and it can pass through a prescaler whose divide choices depend on the channel variant. A blanking input can gate the counter in one of five ways. The counter can return to zero when it meets the compare value, or it can run on to wrap-around.

Target and overflow events set sticky status flags. One read of the status clears both flags. When the matching enable bit is set, an event also raises a single-cycle interrupt pulse. The blanking strobe and the alternate tick are produced elsewhere and arrive as inputs.

The parameters are:
- `WIDTH`: counter width, 16 or 32.
- `PRESCALE_KIND`: 0 means no prescaler. 1 is the legacy variant, where mode bit 9 selects divide by 8. 2 is the wide variant, which uses a 2-bit field.
- `ALT_CLK`: enables clock select.

Top module: `rtmr_channel`

## Requirements
- R1: After synchronous reset:
  - count, compare and mode are 0;
  - both status flags are clear;
  - `irq` is low.
- R2: While mode bit 6 (master enable) is 0, the count holds its value. The only exception is a register write.
- R3: Register addresses are 0 for count, 1 for mode/status and 2 for compare. A write to address 1 loads the mode and sets the count to 0 on the same edge. A write to address 0 loads the count directly.
- R4: Mode bits 2:0 select the gate. Gate code 000 counts on every tick with no gating. The unused codes 010, 100 and 110 behave the same as 000.
- R5: With mode bit 3 set, a tick that finds count equal to compare returns the count to 0. The count therefore runs 0..compare. Any tick with count equal to compare is a target event.
- R6: Without reset-on-target, a tick from all-ones wraps to 0 and sets the overflow flag. A target event sets the target flag.
- R7: A read of address 1 returns the target flag in bit 11, the overflow flag in bit 12 and the stored mode bits elsewhere. The read clears both flags. An event in the same cycle wins over the clear.
- R8: `irq` is high for one cycle, together with the flag setting. It is raised for a target event when mode bit 4 is set, and for an overflow when mode bit 5 is set. A flag still sets when its enable is clear.
- R9: The prescaler divides the tick as follows:
  - In the wide variant, mode bits 14:13 = 00, 01, 10, 11 give divide by 1, 8, 16 and 256. The first divided tick comes on the Nth source tick after the mode write.
  - In the legacy variant, mode bit 9 gives divide by 8.
- R10: With mode bit 8 set, the tick source is the `alt_tick` strobe instead of the system clock.
- R11: Blanking is synchronized over two flops, so the counter reacts on the third clock edge after a change of `blank_in`. Gate 001 holds the count during blanking and clears it to 0 when blanking ends.
- R12: Gate 011 counts all the time and clears the count to 0 at each end of blanking.
- R13: Gate 101 holds the count outside blanking. It clears the count to 0 when blanking starts and counts while blanking lasts.
- R14: Gate 111 holds the count until the first end of blanking, clears it there, and after that counts freely whatever blanking does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the flags) |
| reg_addr | input | 2 | Register address: 0 count, 1 mode/status, 2 compare |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for `reg_addr`, combinational |
| blank_in | input | 1 | Asynchronous blanking level, active high |
| alt_tick | input | 1 | Alternate tick strobe, one clock wide |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench counts clock edges exactly around each blanking edge. A gate that reacts one stage early or late, or that clears on the wrong edge (start versus end of blanking), therefore shows up as an off-by-one or a non-zero count. Reset-on-target is checked at the cycle where count equals compare: a design that compared one step ahead would wrap at compare-1, and one that ignored the bit would run past compare. The wrap from all-ones, the clear-on-read of the flags and the second read afterwards are all sampled. A design that leaked `irq` with its enable clear, or held a flag after the read, is caught. Each prescale setting is probed one edge before and at its divided tick.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    // register addresses
    localparam logic [1:0] RA_COUNT = 2'd0;
    localparam logic [1:0] RA_MODE  = 2'd1;
    localparam logic [1:0] RA_CMP   = 2'd2;

    // prescaler variants
    localparam int PK_NONE   = 0;
    localparam int PK_LEGACY = 1;
    localparam int PK_WIDE   = 2;

    // status flag positions in the mode/status word
    localparam int ST_TGT_BIT = 11;
    localparam int ST_OVF_BIT = 12;

    typedef enum logic [2:0] {
        GT_FREE    = 3'b000,
        GT_HOLD    = 3'b001,
        GT_RSV2    = 3'b010,
        GT_CLREND  = 3'b011,
        GT_RSV4    = 3'b100,
        GT_INBLANK = 3'b101,
        GT_RSV6    = 3'b110,
        GT_ARMED   = 3'b111
    } gate_e;

    typedef struct packed {
        logic [1:0] pre_wide;
        logic       pre_legacy;
        logic       clk_sel;
        logic       enable;
        logic       ovf_ie;
        logic       tgt_ie;
        logic       rst_on_tgt;
        gate_e      gate;
    } mode_t;

    typedef struct packed {
        logic run;
        logic clr;
    } gate_ctl_t;

    function automatic mode_t mode_from_word(input logic [15:0] w);
        mode_t m;
        m.gate       = gate_e'(w[2:0]);
        m.rst_on_tgt = w[3];
        m.tgt_ie     = w[4];
        m.ovf_ie     = w[5];
        m.enable     = w[6];
        m.clk_sel    = w[8];
        m.pre_legacy = w[9];
        m.pre_wide   = w[14:13];
        return m;
    endfunction

    function automatic logic [15:0] status_word(input mode_t m, input logic tgt,
                                                input logic ovf);
        logic [15:0] w;
        w             = 16'h0000;
        w[2:0]        = m.gate;
        w[3]          = m.rst_on_tgt;
        w[4]          = m.tgt_ie;
        w[5]          = m.ovf_ie;
        w[6]          = m.enable;
        w[8]          = m.clk_sel;
        w[9]          = m.pre_legacy;
        w[ST_TGT_BIT] = tgt;
        w[ST_OVF_BIT] = ovf;
        w[14:13]      = m.pre_wide;
        return w;
    endfunction

    // log2 of the prescale divisor for a channel variant
    function automatic logic [3:0] pre_log2(input int kind, input mode_t m);
        logic [3:0] s;
        s = 4'd0;
        if (kind == PK_LEGACY) begin
            s = m.pre_legacy ? 4'd3 : 4'd0;
        end else if (kind == PK_WIDE) begin
            case (m.pre_wide)
                2'b00:   s = 4'd0;
                2'b01:   s = 4'd3;
                2'b10:   s = 4'd4;
                default: s = 4'd8;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/rtmr_blank_sync.sv
module rtmr_blank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_in,
    output logic blank_lvl,
    output logic blank_rise,
    output logic blank_fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= blank_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], blank_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign blank_lvl  = chain_q[LAST];
    assign blank_rise = chain_q[LAST] & ~prev_q;
    assign blank_fall = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/rtmr_tick_gen.sv
module rtmr_tick_gen
    import rtmr_pkg::*;
#(
    parameter int PRESCALE_KIND = PK_WIDE,
    parameter bit ALT_CLK       = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       enable,
    input  logic       alt_sel,
    input  logic [3:0] shift,
    input  logic       alt_tick,
    output logic       tick
);
    logic base;

    generate
        if (ALT_CLK) begin : g_alt
            assign base = alt_sel ? alt_tick : 1'b1;
        end else begin : g_sys
            assign base = 1'b1;
        end
    endgenerate

    generate
        if (PRESCALE_KIND == PK_NONE) begin : g_nodiv
            assign tick = enable & base;
        end else begin : g_div
            logic [7:0] pc_q;
            logic [8:0] div_m1;
            logic       wrap;

            assign div_m1 = 9'((9'd1 << shift) - 9'd1);
            assign wrap   = ({1'b0, pc_q} >= div_m1);
            assign tick   = enable & base & wrap;

            always_ff @(posedge clk) begin
                if (rst || clear)         pc_q <= 8'd0;
                else if (enable && base)  pc_q <= wrap ? 8'd0 : pc_q + 8'd1;
            end

            // R9: phase counter never passes the selected divisor
            p_pre_bound_r9: assert property (@(posedge clk) disable iff (rst)
                ({1'b0, pc_q} <= div_m1));
        end
    endgenerate

endmodule

// File: rtl/rtmr_gate_ctrl.sv
module rtmr_gate_ctrl
    import rtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      enable,
    input  gate_e     gate,
    input  logic      blank_lvl,
    input  logic      blank_rise,
    input  logic      blank_fall,
    output gate_ctl_t ctl
);
    logic freed_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            freed_q <= 1'b0;
        else if (enable && gate == GT_ARMED && blank_fall)
            freed_q <= 1'b1;
    end

    always_comb begin
        ctl.run = 1'b1;
        ctl.clr = 1'b0;
        case (gate)
            GT_HOLD: begin
                ctl.run = ~blank_lvl;
                ctl.clr = blank_fall;
            end
            GT_CLREND: begin
                ctl.clr = blank_fall;
            end
            GT_INBLANK: begin
                ctl.run = blank_lvl;
                ctl.clr = blank_rise;
            end
            GT_ARMED: begin
                ctl.run = freed_q;
                ctl.clr = blank_fall & ~freed_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
    import rtmr_pkg::*;
#(
    parameter int WIDTH         = 32,
    parameter int PRESCALE_KIND = PK_WIDE,
    parameter bit ALT_CLK       = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             blank_in,
    input  logic             alt_tick,
    output logic             irq
);
    localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    mode_t            mode_q;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] cmp_q;
    logic             st_tgt_q;
    logic             st_ovf_q;
    logic             irq_q;

    logic wr_mode, wr_count, wr_cmp, rd_status;
    logic blank_lvl, blank_rise, blank_fall;
    logic tick;
    gate_ctl_t gctl;
    logic step, hit, wrap_ovf, gate_clr;

    assign wr_mode   = reg_wr && reg_addr == RA_MODE;
    assign wr_count  = reg_wr && reg_addr == RA_COUNT;
    assign wr_cmp    = reg_wr && reg_addr == RA_CMP;
    assign rd_status = reg_rd && reg_addr == RA_MODE;

    rtmr_blank_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .blank_in   (blank_in),
        .blank_lvl  (blank_lvl),
        .blank_rise (blank_rise),
        .blank_fall (blank_fall)
    );

    rtmr_tick_gen #(.PRESCALE_KIND(PRESCALE_KIND), .ALT_CLK(ALT_CLK)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clear    (wr_mode),
        .enable   (mode_q.enable),
        .alt_sel  (mode_q.clk_sel),
        .shift    (pre_log2(PRESCALE_KIND, mode_q)),
        .alt_tick (alt_tick),
        .tick     (tick)
    );

    rtmr_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .clear      (wr_mode),
        .enable     (mode_q.enable),
        .gate       (mode_q.gate),
        .blank_lvl  (blank_lvl),
        .blank_rise (blank_rise),
        .blank_fall (blank_fall),
        .ctl        (gctl)
    );

    assign gate_clr = mode_q.enable && gctl.clr && !wr_mode && !wr_count;
    assign step     = mode_q.enable && gctl.run && tick && !gctl.clr
                      && !wr_mode && !wr_count;
    assign hit      = step && (count_q == cmp_q);
    assign wrap_ovf = step && (count_q == CNT_MAX) && !(mode_q.rst_on_tgt && hit);

    // counter and mode
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_from_word(16'h0000);
            count_q <= '0;
        end else if (wr_mode) begin
            mode_q  <= mode_from_word(reg_wdata[15:0]);
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= reg_wdata;
        end else if (gate_clr) begin
            count_q <= '0;
        end else if (hit && mode_q.rst_on_tgt) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (wr_cmp) cmp_q <= reg_wdata;
    end

    // sticky flags and interrupt pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            st_tgt_q <= 1'b0;
            st_ovf_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            st_tgt_q <= hit      | (st_tgt_q & ~rd_status);
            st_ovf_q <= wrap_ovf | (st_ovf_q & ~rd_status);
            irq_q    <= (hit & mode_q.tgt_ie) | (wrap_ovf & mode_q.ovf_ie);
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (reg_addr)
            RA_COUNT: reg_rdata = count_q;
            RA_MODE:  reg_rdata = WIDTH'(status_word(mode_q, st_tgt_q, st_ovf_q));
            RA_CMP:   reg_rdata = cmp_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: count frozen while disabled and not written
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.enable && !wr_count && !wr_mode) |=> $stable(count_q));

    // R3: mode write leaves the count at zero
    p_mode_clears_r3: assert property (@(posedge clk) disable iff (rst)
        wr_mode |=> (count_q == '0));

    // R7: a status read with no new event leaves both flags clear
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !hit && !wrap_ovf) |=> (!st_tgt_q && !st_ovf_q));

    // R8: every interrupt pulse coincides with a set flag
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (st_tgt_q || st_ovf_q));

    // R13: in-blank gate never moves the count outside blanking
    p_inblank_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mode_q.enable && mode_q.gate == GT_INBLANK && !blank_lvl
         && !wr_mode && !wr_count) |=> $stable(count_q));

endmodule

// File: tb/rtmr_channel_bench.sv
`timescale 1ns/1ps
module rtmr_channel_bench;

    localparam int W = 32;
    localparam logic [15:0] EN  = 16'h0040;
    localparam logic [15:0] ROT = 16'h0008;
    localparam logic [15:0] TIE = 16'h0010;
    localparam logic [15:0] OIE = 16'h0020;
    localparam logic [15:0] CKS = 16'h0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          blank_in = 1'b0;
    logic          alt_tick = 1'b0;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rtmr_channel u_rtmr_channel (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .blank_in  (blank_in),
        .alt_tick  (alt_tick),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [W-1:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_status(output logic [W-1:0] v);
        reg_addr = 2'd1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        cyc(1);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; blank_in = 1'b0; alt_tick = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        do_reset();
        peek(2'd0, v); check("R1 count", v, 0);
        peek(2'd1, v); check("R1 mode/status", v, 0);
        peek(2'd2, v); check("R1 compare", v, 0);
        check("R1 irq", W'(irq), 0);
    endtask

    task automatic t_free();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN));
        peek(2'd0, v); check("R3 count after mode write", v, 0);
        cyc(10);
        peek(2'd0, v); check("R4 free run", v, 10);
        do_reset();
        wr(2'd1, W'(EN | 16'h0002));
        cyc(7);
        peek(2'd0, v); check("R4 unused gate code", v, 7);
    endtask

    task automatic t_off_and_write();
        logic [W-1:0] v;
        do_reset();
        wr(2'd0, 5);
        peek(2'd0, v); check("R3 count load", v, 5);
        cyc(8);
        peek(2'd0, v); check("R2 disabled hold", v, 5);
        wr(2'd1, W'(EN));
        cyc(3);
        wr(2'd0, 100);
        cyc(2);
        peek(2'd0, v); check("R3 count load then run", v, 102);
        wr(2'd1, W'(EN));
        peek(2'd0, v); check("R3 mode rewrite clears", v, 0);
    endtask

    task automatic t_target();
        logic [W-1:0] v;
        do_reset();
        wr(2'd2, 4);
        wr(2'd1, W'(EN | ROT | TIE));
        cyc(4);
        peek(2'd0, v); check("R5 reaches compare", v, 4);
        check("R8 no irq before hit", W'(irq), 0);
        cyc(1);
        peek(2'd0, v); check("R5 returns to zero", v, 0);
        check("R8 irq on target", W'(irq), 1);
        cyc(1);
        peek(2'd0, v); check("R5 restart", v, 1);
        check("R8 irq one cycle", W'(irq), 0);
        rd_status(v);
        check("R7 target flag bit 11", W'(v[11]), 1);
        check("R7 overflow flag clear", W'(v[12]), 0);
        check("R7 mode bits readback", W'(v[10:0]), W'(EN | ROT | TIE));
        rd_status(v);
        check("R7 target flag cleared by read", W'(v[11]), 0);
    endtask

    task automatic t_overflow();
        logic [W-1:0] v;
        do_reset();
        wr(2'd2, 5);
        wr(2'd1, W'(EN | OIE));
        wr(2'd0, 32'hFFFF_FFFE);
        cyc(1);
        peek(2'd0, v); check("R6 at all-ones", v, 32'hFFFF_FFFF);
        check("R8 no irq yet", W'(irq), 0);
        cyc(1);
        peek(2'd0, v); check("R6 wraps to zero", v, 0);
        check("R8 irq on overflow", W'(irq), 1);
        rd_status(v);
        check("R6 overflow flag bit 12", W'(v[12]), 1);
        check("R6 no target flag", W'(v[11]), 0);
        cyc(5);
        peek(2'd0, v); check("R6 runs past compare", v, 6);
        check("R8 no irq with target enable clear", W'(irq), 0);
        rd_status(v);
        check("R8 flag still set without enable", W'(v[11]), 1);
        check("R7 overflow flag cleared by earlier read", W'(v[12]), 0);
    endtask

    task automatic t_prescale();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | 16'h2000));
        cyc(15);
        peek(2'd0, v); check("R9 div8 before tick", v, 1);
        cyc(1);
        peek(2'd0, v); check("R9 div8", v, 2);
        wr(2'd1, W'(EN | 16'h4000));
        cyc(31);
        peek(2'd0, v); check("R9 div16 before tick", v, 1);
        cyc(1);
        peek(2'd0, v); check("R9 div16", v, 2);
        wr(2'd1, W'(EN | 16'h6000));
        cyc(255);
        peek(2'd0, v); check("R9 div256 before tick", v, 0);
        cyc(1);
        peek(2'd0, v); check("R9 div256", v, 1);
    endtask

    task automatic t_alt();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | CKS));
        cyc(5);
        peek(2'd0, v); check("R10 idle without strobe", v, 0);
        for (int i = 0; i < 3; i++) begin
            alt_tick = 1'b1; cyc(1);
            alt_tick = 1'b0; cyc(2);
        end
        peek(2'd0, v); check("R10 counts strobes", v, 3);
    endtask

    task automatic t_gate_hold();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | 16'h0001));
        cyc(4);
        blank_in = 1'b1; cyc(2);
        peek(2'd0, v); check("R11 sync latency", v, 6);
        cyc(10);
        peek(2'd0, v); check("R11 hold in blanking", v, 6);
        blank_in = 1'b0; cyc(5);
        peek(2'd0, v); check("R11 restart after blanking", v, 2);
    endtask

    task automatic t_gate_clrend();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | 16'h0003));
        cyc(4);
        blank_in = 1'b1; cyc(6);
        peek(2'd0, v); check("R12 counts in blanking", v, 10);
        blank_in = 1'b0; cyc(5);
        peek(2'd0, v); check("R12 clear at end", v, 2);
    endtask

    task automatic t_gate_inblank();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | 16'h0005));
        cyc(6);
        peek(2'd0, v); check("R13 hold outside", v, 0);
        blank_in = 1'b1; cyc(5);
        peek(2'd0, v); check("R13 clear at start", v, 2);
        cyc(3);
        peek(2'd0, v); check("R13 counts in blanking", v, 5);
        blank_in = 1'b0; cyc(2);
        cyc(6);
        peek(2'd0, v); check("R13 stops after blanking", v, 7);
    endtask

    task automatic t_gate_armed();
        logic [W-1:0] v;
        do_reset();
        wr(2'd1, W'(EN | 16'h0007));
        cyc(5);
        peek(2'd0, v); check("R14 waits", v, 0);
        blank_in = 1'b1; cyc(6);
        peek(2'd0, v); check("R14 waits in blanking", v, 0);
        blank_in = 1'b0; cyc(5);
        peek(2'd0, v); check("R14 starts after end", v, 2);
        blank_in = 1'b1; cyc(6);
        blank_in = 1'b0; cyc(5);
        peek(2'd0, v); check("R14 ungated afterwards", v, 13);
    endtask

    initial begin
        #20000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_free();
        t_off_and_write();
        t_target();
        t_overflow();
        t_prescale();
        t_alt();
        t_gate_hold();
        t_gate_clrend();
        t_gate_inblank();
        t_gate_armed();
        summary();
    end

endmodule